// File: doc/BRIEF.md
# Transmit/Receive-Switched GPIO Controller

This block sits between a register write port and the pad drivers of a radio front end with two daughterboard sides. Each side owns two 16-pin banks, one facing its transmit chain and one facing its receive chain. Software programs the banks through a single address/data strobe. For every pin it sets a direction bit, a manual level and, optionally, a pair of automatic levels. The automatic levels are chosen in hardware by the side's current transmit/receive state, so antenna switches, power-amplifier enables and receiver enables follow the data path without software on the timing path.

Each side runs a two-state machine. `ST_RECV` is the reset state. It moves to `ST_XMIT` on the first clock edge where that side's transmit-active input is high, which happens when its TX FIFO holds data. It returns to `ST_RECV` on the first edge where the input is low. Both banks of a side follow that one state. Pad input levels are synchronized and returned as one 32-bit readback word per side.

A register address holds a register kind in bits 4:2 and a bank number in bits 1:0. The kinds are: 0 direction, 1 manual level, 2 automatic-select, 3 transmit level, 4 receive level. Kinds 5 to 7 are unused. Banks 0 and 1 are the TX and RX banks of side A, and banks 2 and 3 are the TX and RX banks of side B.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, every `pad_oe`, `pad_out` and `rdbk` bit is 0, and both sides are in `ST_RECV`.
- R2: A write to the direction register (kind 0) or the manual-level register (kind 1) uses `wr_data[31:16]` as a per-bit write mask and `wr_data[15:0]` as the new value. Only the bits whose mask bit is 1 change, from the edge of the write onward.
- R3: The automatic-select (kind 2), transmit-level (kind 3) and receive-level (kind 4) registers take `wr_data[15:0]` as a plain value, and `wr_data[31:16]` has no effect on them.
- R4: Address bits 1:0 select the bank. Banks 0 and 1 follow `tx_active[0]` (side A) and banks 2 and 3 follow `tx_active[1]` (side B). Bank b occupies pin bits `[16b+15:16b]` of `pad_in`, `pad_out` and `pad_oe`.
- R5: For a pin whose automatic-select bit is 1, `pad_out` equals the transmit-level bit while its side is in `ST_XMIT`, and the receive-level bit in `ST_RECV`.
- R6: For a pin whose automatic-select bit is 0, `pad_out` equals the manual-level bit.
- R7: `pad_oe` equals the direction register bit for bit, and changes only on an edge that writes that register.
- R8: A side enters `ST_XMIT` on the first clock edge where its `tx_active` bit is 1, and returns to `ST_RECV` on the first edge where it is 0. The pins follow on that same edge.
- R9: The TX bank and the RX bank of a side switch together on a state change, and the other side's pins are unaffected.
- R10: `rdbk[32s+31:32s+16]` holds the RX-bank pad levels and `rdbk[32s+15:32s]` holds the TX-bank pad levels of side s. Each level is the one sampled two clock edges earlier.
- R11: A write with a register kind of 5, 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register kind in bits 4:2, bank in bits 1:0 |
| wr_data | input | 32 | Write data; mask in bits 31:16 for kinds 0 and 1 |
| tx_active | input | 2 | Per-side transmit-active indication, bit 0 is side A |
| pad_in | input | 64 | Pad input levels, 16 per bank |
| pad_out | output | 64 | Pad drive levels, 16 per bank |
| pad_oe | output | 64 | Pad output enables, 1 = driven |
| rdbk | output | 64 | Synchronized readback, 32 bits per side |

## Verification
The bench targets masked writes whose mask is partial. A design that ignored the mask would overwrite neighbouring direction or level bits. The bench also writes the plain automatic registers with a non-zero upper half, which catches a design that decodes a mask there. Transmit-active pulses one cycle long, and states held for a long time, expose a state machine that is off by an edge, stuck, or shared between sides. Such a design would drive transmit levels on the wrong side or on only one bank. Writes with unused kind codes, and pad patterns that change every cycle, catch stray decodes and a synchronizer with the wrong depth or with swapped readback halves.

// File: rtl/atr_gpio_pkg.sv
package atr_gpio_pkg;

    // Register kinds decoded from the upper address bits
    localparam logic [2:0] RK_DIR   = 3'd0;
    localparam logic [2:0] RK_LEVEL = 3'd1;
    localparam logic [2:0] RK_ASEL  = 3'd2;
    localparam logic [2:0] RK_TXLVL = 3'd3;
    localparam logic [2:0] RK_RXLVL = 3'd4;

    localparam int KIND_W = 3;

    typedef enum logic [0:0] {
        ST_RECV = 1'b0,
        ST_XMIT = 1'b1
    } side_st_t;

endpackage

// File: rtl/atr_side_fsm.sv
module atr_side_fsm
    import atr_gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    output logic xmit
);

    side_st_t st_q, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RECV;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_RECV: if (tx_active)  st_nx = ST_XMIT;
            ST_XMIT: if (!tx_active) st_nx = ST_RECV;
        endcase
    end

    always_comb begin
        xmit = (st_q == ST_XMIT);
    end

endmodule

// File: rtl/atr_bank_regs.sv
module atr_bank_regs
    import atr_gpio_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [KIND_W-1:0] kind,
    input  logic [2*PINS-1:0] data,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   lvl_q,
    output logic [PINS-1:0]   asel_q,
    output logic [PINS-1:0]   txl_q,
    output logic [PINS-1:0]   rxl_q
);

    logic [PINS-1:0] wmask, wval;

    always_comb begin
        wmask = data[2*PINS-1:PINS];
        wval  = data[PINS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            lvl_q  <= '0;
            asel_q <= '0;
            txl_q  <= '0;
            rxl_q  <= '0;
        end else if (sel) begin
            case (kind)
                RK_DIR:   dir_q  <= (dir_q & ~wmask) | (wval & wmask);
                RK_LEVEL: lvl_q  <= (lvl_q & ~wmask) | (wval & wmask);
                RK_ASEL:  asel_q <= wval;
                RK_TXLVL: txl_q  <= wval;
                RK_RXLVL: rxl_q  <= wval;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/atr_pin_mux.sv
module atr_pin_mux #(
    parameter int PINS = 16
) (
    input  logic            xmit,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] lvl_q,
    input  logic [PINS-1:0] asel_q,
    input  logic [PINS-1:0] txl_q,
    input  logic [PINS-1:0] rxl_q,
    output logic [PINS-1:0] drv,
    output logic [PINS-1:0] oe
);

    logic [PINS-1:0] auto_lvl;

    always_comb begin
        auto_lvl = xmit ? txl_q : rxl_q;
        drv      = (asel_q & auto_lvl) | (~asel_q & lvl_q);
        oe       = dir_q;
    end

endmodule

// File: rtl/atr_in_sync.sv
module atr_in_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/atr_gpio_ctrl.sv
module atr_gpio_ctrl
    import atr_gpio_pkg::*;
#(
    parameter  int PINS   = 16,
    parameter  int SIDES  = 2,
    parameter  int SYNC_N = 2,
    localparam int BANKS  = 2 * SIDES,
    localparam int BW     = $clog2(BANKS),
    localparam int AW     = BW + KIND_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [2*PINS-1:0]     wr_data,
    input  logic [SIDES-1:0]      tx_active,
    input  logic [BANKS*PINS-1:0] pad_in,
    output logic [BANKS*PINS-1:0] pad_out,
    output logic [BANKS*PINS-1:0] pad_oe,
    output logic [BANKS*PINS-1:0] rdbk
);

    logic [SIDES-1:0]      side_xmit;
    logic [BANKS*PINS-1:0] reg_dir, reg_lvl, reg_asel, reg_txl, reg_rxl;
    logic [BANKS*PINS-1:0] pad_sync;
    logic [KIND_W-1:0]     wr_kind;
    logic [BW-1:0]         wr_bank;

    always_comb begin
        wr_kind = wr_addr[AW-1:BW];
        wr_bank = wr_addr[BW-1:0];
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        atr_side_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .tx_active (tx_active[s]),
            .xmit      (side_xmit[s])
        );
        // readback: RX bank in the upper half, TX bank in the lower half
        assign rdbk[2*s*PINS +: PINS]     = pad_sync[(2*s)*PINS +: PINS];
        assign rdbk[(2*s+1)*PINS +: PINS] = pad_sync[(2*s+1)*PINS +: PINS];
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bank_sel;
        assign bank_sel = wr_en && (wr_bank == BW'(b));

        atr_bank_regs #(.PINS(PINS)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (bank_sel),
            .kind   (wr_kind),
            .data   (wr_data),
            .dir_q  (reg_dir[b*PINS +: PINS]),
            .lvl_q  (reg_lvl[b*PINS +: PINS]),
            .asel_q (reg_asel[b*PINS +: PINS]),
            .txl_q  (reg_txl[b*PINS +: PINS]),
            .rxl_q  (reg_rxl[b*PINS +: PINS])
        );

        atr_pin_mux #(.PINS(PINS)) u_mux (
            .xmit   (side_xmit[b/2]),
            .dir_q  (reg_dir[b*PINS +: PINS]),
            .lvl_q  (reg_lvl[b*PINS +: PINS]),
            .asel_q (reg_asel[b*PINS +: PINS]),
            .txl_q  (reg_txl[b*PINS +: PINS]),
            .rxl_q  (reg_rxl[b*PINS +: PINS]),
            .drv    (pad_out[b*PINS +: PINS]),
            .oe     (pad_oe[b*PINS +: PINS])
        );
    end

    atr_in_sync #(.W(BANKS*PINS), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pad_sync)
    );

endmodule

// File: rtl/atr_gpio_chk.sv
module atr_gpio_chk #(
    parameter int PINS  = 16,
    parameter int SIDES = 2,
    parameter int AW    = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [AW-1:0]             wr_addr,
    input logic [PINS-1:0]           wr_mask,
    input logic [SIDES-1:0]          tx_active,
    input logic [2*SIDES*PINS-1:0]   pad_in,
    input logic [2*SIDES*PINS-1:0]   pad_out,
    input logic [2*SIDES*PINS-1:0]   pad_oe,
    input logic [2*SIDES*PINS-1:0]   rdbk,
    input logic [SIDES-1:0]          side_xmit,
    input logic [2*SIDES*PINS-1:0]   reg_asel,
    input logic [2*SIDES*PINS-1:0]   reg_txl,
    input logic [2*SIDES*PINS-1:0]   reg_rxl
);

    localparam int BANKS = 2 * SIDES;
    localparam int BW    = $clog2(BANKS);

    logic [1:0] run_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_s
        p_enter_xmit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            tx_active[s] |=> side_xmit[s]);
        p_leave_xmit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_active[s] |=> !side_xmit[s]);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_b
        p_dir_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(b)) |=>
            (((pad_oe[b*PINS +: PINS] ^ $past(pad_oe[b*PINS +: PINS])) & ~$past(wr_mask)) == '0));
        p_auto_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((pad_out[b*PINS +: PINS] ^ (side_xmit[b/2] ? reg_txl[b*PINS +: PINS]
                                                       : reg_rxl[b*PINS +: PINS]))
             & reg_asel[b*PINS +: PINS]) == '0);
    end

    p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr[AW-1:BW] != '0) |=> $stable(pad_oe));

    p_rdbk_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2) |-> (rdbk == $past(pad_in, 2)));

endmodule

bind atr_gpio_ctrl atr_gpio_chk #(.PINS(PINS), .SIDES(SIDES), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_mask   (wr_data[2*PINS-1:PINS]),
    .tx_active (tx_active),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .rdbk      (rdbk),
    .side_xmit (side_xmit),
    .reg_asel  (reg_asel),
    .reg_txl   (reg_txl),
    .reg_rxl   (reg_rxl)
);

// File: tb/atr_gpio_ctrl_tb.sv
`timescale 1ns/1ps
module atr_gpio_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  tx_act = '0;
    logic [63:0] pad_in = '0;
    logic [63:0] pad_out, pad_oe, rdbk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] m_dir [4];
    logic [15:0] m_lvl [4];
    logic [15:0] m_asel[4];
    logic [15:0] m_txl [4];
    logic [15:0] m_rxl [4];
    logic [1:0]  m_xmit;
    logic [63:0] m_s1, m_s2;

    always #2.5 clk = ~clk;

    atr_gpio_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tx_active (tx_act),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .rdbk      (rdbk)
    );

    function automatic logic [63:0] exp_out();
        logic [63:0] r;
        for (int b = 0; b < 4; b++) begin
            logic [15:0] a;
            a = m_xmit[b/2] ? m_txl[b] : m_rxl[b];
            r[b*16 +: 16] = (m_asel[b] & a) | (~m_asel[b] & m_lvl[b]);
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_oe();
        logic [63:0] r;
        for (int b = 0; b < 4; b++) r[b*16 +: 16] = m_dir[b];
        return r;
    endfunction

    function automatic logic [63:0] exp_rdbk();
        // side s: RX bank (2s+1) high half, TX bank (2s) low half
        logic [63:0] r;
        for (int s = 0; s < 2; s++) begin
            r[s*32 +: 16]      = m_s2[(2*s)*16 +: 16];
            r[s*32 + 16 +: 16] = m_s2[(2*s+1)*16 +: 16];
        end
        return r;
    endfunction

    task automatic model_clear();
        for (int b = 0; b < 4; b++) begin
            m_dir[b] = '0; m_lvl[b] = '0; m_asel[b] = '0; m_txl[b] = '0; m_rxl[b] = '0;
        end
        m_xmit = '0; m_s1 = '0; m_s2 = '0;
    endtask

    task automatic model_edge();
        logic [2:0]  k;
        logic [1:0]  b;
        logic [15:0] m, v;
        if (!rst_n) begin
            model_clear();
            return;
        end
        if (wr_en) begin
            k = wr_addr[4:2]; b = wr_addr[1:0];
            m = wr_data[31:16]; v = wr_data[15:0];
            case (k)
                3'd0: m_dir[b]  = (m_dir[b] & ~m) | (v & m);
                3'd1: m_lvl[b]  = (m_lvl[b] & ~m) | (v & m);
                3'd2: m_asel[b] = v;
                3'd3: m_txl[b]  = v;
                3'd4: m_rxl[b]  = v;
                default: ;
            endcase
        end
        m_xmit = tx_act;
        m_s2 = m_s1;
        m_s1 = pad_in;
    endtask

    task automatic check64(string req, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s): actual %h expected %h", req, tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check64("R7", tag, pad_oe, exp_oe());
        check64("R5/R6", tag, pad_out, exp_out());
        check64("R10", tag, rdbk, exp_rdbk());
    endtask

    // one clock: inputs set before, model follows the edge, compare at negedge
    task automatic cyc(string tag);
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(logic [2:0] kind, logic [1:0] bank, logic [31:0] d, string tag);
        wr_en = 1'b1; wr_addr = {kind, bank}; wr_data = d;
        cyc(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        pad_in = 64'hDEAD_BEEF_0123_4567;
        tx_act = 2'b11;
        // R1: reset holds everything at zero
        repeat (3) cyc("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        tx_act = 2'b00;
        cyc("R1 after reset");

        // R2: masked direction writes
        wr(3'd0, 2'd0, {16'h00FF, 16'hABCD}, "R2 dir low byte");
        wr(3'd0, 2'd0, {16'hF000, 16'h1234}, "R2 dir top nibble");
        wr(3'd0, 2'd0, {16'h0000, 16'hFFFF}, "R2 empty mask");
        // R6: manual level, select off
        wr(3'd1, 2'd1, {16'h0FF0, 16'hA5A5}, "R6 level bank1");
        wr(3'd1, 2'd0, {16'hFFFF, 16'h3C3C}, "R6 level bank0");
        // R3: plain automatic registers, upper half ignored
        wr(3'd2, 2'd0, 32'h0000_0F0F, "R3 asel bank0");
        wr(3'd3, 2'd0, 32'h1234_5555, "R3 txl bank0");
        wr(3'd4, 2'd0, 32'hFFFF_AAAA, "R3 rxl bank0");
        wr(3'd2, 2'd1, 32'hFFFF_FF00, "R3 asel bank1");
        wr(3'd3, 2'd1, 32'h0000_C300, "R3 txl bank1");
        wr(3'd4, 2'd1, 32'h5A5A_0000, "R3 rxl bank1");

        // R8/R9: one-cycle transmit pulse on side A, both banks switch
        tx_act = 2'b01;
        cyc("R8 enter xmit");
        tx_act = 2'b00;
        cyc("R8 leave xmit");
        tx_act = 2'b01;
        repeat (4) cyc("R9 both banks of side A");

        // R4: side B banks follow tx_active[1] only
        wr(3'd2, 2'd2, 32'h0000_FFFF, "R4 asel bank2");
        wr(3'd3, 2'd2, 32'h0000_1111, "R4 txl bank2");
        wr(3'd4, 2'd3, 32'h0000_2222, "R4 rxl bank3");
        wr(3'd2, 2'd3, 32'h0000_00FF, "R4 asel bank3");
        wr(3'd0, 2'd3, 32'hFFFF_FFFF, "R4 dir bank3");
        tx_act = 2'b10;
        repeat (3) cyc("R4 side B xmit");
        tx_act = 2'b00;
        cyc("R4 both recv");

        // R11: unused kinds write nothing
        wr(3'd5, 2'd0, 32'hFFFF_FFFF, "R11 kind5");
        wr(3'd6, 2'd1, 32'hFFFF_FFFF, "R11 kind6");
        wr(3'd7, 2'd2, 32'hFFFF_FFFF, "R11 kind7");

        // R10: changing pads every cycle
        for (int i = 0; i < 8; i++) begin
            pad_in = {$urandom, $urandom};
            cyc("R10 pad walk");
        end

        // random mix
        for (int i = 0; i < 3000; i++) begin
            wr_en   = ($urandom % 3) != 0;
            wr_addr = 5'($urandom % 32);
            wr_data = $urandom;
            if (($urandom % 4) == 0) tx_act = 2'($urandom);
            pad_in  = {$urandom, $urandom};
            cyc("R5 random");
        end
        wr_en = 1'b0;
        cyc("R5 final");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule